// File: doc/BRIEF.md
# Four-Digit Blanking and Dimming Gate

This block decides, for each of four character positions, whether that position's row drivers may be enabled in the present clock cycle. It also decides whether the position shows its stored character or the cursor pattern. The display controller samples the two output vectors every cycle and applies them while it scans the font data. Font decoding and row or column scanning take place outside this block.

Three sources can switch positions off. The first is an active-low blank pin. The second is a master-blank control bit. The third is a per-position keep-lit bit that shields a position from the first two. A compatibility switch turns off every register-based feature, so that only the blank pin can blank the display. An internal counter runs freely with a period of 100 ticks. Its value is compared against a threshold chosen by a 3-bit brightness level, which gives eight nonlinear duty steps. A position in cursor mode is further gated so that it lights only in the first half of each counter period, which produces the half-brightness cursor.

Top module: `blank_dim_gate`

## Requirements
- R1: While `rst` is high, `drive_en_o` and `show_cursor_o` are all zeros and the dimming count is held at zero.
- R2: When `compat_i` is 1, a position is driven exactly when `blank_n_i` is 1. In this mode `master_blank_i`, `keep_lit_i` and `level_i` have no effect, and a position that is not in cursor mode is driven on every tick.
- R3: When `compat_i` is 0, position d is blanked if (`blank_n_i` is 0 or `master_blank_i` is 1) and `keep_lit_i[d]` is 0. A 1 in `keep_lit_i[d]` keeps position d lit against both blanking sources.
- R4: When `compat_i` is 0, an unblanked position outside cursor mode is driven only while the dimming count is below the threshold for `level_i`. Levels 0 to 7 give thresholds 100, 60, 40, 27, 17, 10, 7 and 3, so level 0 is the brightest. Over any 100 consecutive ticks, the number of driven ticks equals the threshold.
- R5: The dimming count is 0 in the first cycle after reset is released. It then increases by one each cycle and returns to 0 after 99, so the duty pattern repeats every 100 cycles.
- R6: `show_cursor_o[d]` is 1 exactly when `cursor_en_i` is 1 and `cursor_bits_i[d]` is 1. Bit d of every per-position vector belongs to position d, and position 0 is the rightmost.
- R7: A position in cursor mode is driven only while the dimming count is below 50, in addition to every other condition. This holds in both modes.
- R8: Each output bit is registered. A change on any input shows on the outputs one clock edge later and not before.
- R9: The cursor selection does not depend on the blank pin, the master blank, the keep-lit bits, the level or the compatibility switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_n_i | input | 1 | External blank pin, 0 blanks |
| cursor_en_i | input | 1 | Global cursor enable |
| compat_i | input | 1 | 1 disables all register-based blanking and dimming |
| master_blank_i | input | 1 | Control bit that blanks all unshielded positions |
| level_i | input | 3 | Brightness level, 0 brightest, 7 dimmest |
| cursor_bits_i | input | 4 | Per-position cursor bit |
| keep_lit_i | input | 4 | Per-position shield against blanking |
| drive_en_o | output | 4 | Per-position row-driver enable |
| show_cursor_o | output | 4 | Per-position cursor-pattern select |

## Verification
The assertions assume that every input is a clean synchronous level that is held for at least one full clock, and that reset is asserted long enough for the counter to start at zero. The bench drives all inputs on the falling edge only, so every value is stable at the next rising edge. The random stimulus biases the blank pin towards 1 and mixes both modes and all eight levels with arbitrary attribute bits. The duty window and the latency checks hold the inputs steady for the full span they examine.

// File: rtl/blank_dim_pkg.sv
package blank_dim_pkg;

    // Register-side controls for the whole display.
    typedef struct packed {
        logic       compat;   // 1: register features ignored
        logic       mblank;   // master blank
        logic [2:0] level;    // brightness level, 0 brightest
    } ctrl_t;

    // Per-position attribute pair.
    typedef struct packed {
        logic cursor;     // cursor requested here
        logic keep_lit;   // shield from blanking
    } attr_t;

    // Duty in percent for each level.
    function automatic int unsigned duty_pct(input logic [2:0] lvl);
        case (lvl)
            3'd0:    return 100;
            3'd1:    return 60;
            3'd2:    return 40;
            3'd3:    return 27;
            3'd4:    return 17;
            3'd5:    return 10;
            3'd6:    return 7;
            default: return 3;
        endcase
    endfunction

    // Duty scaled to the counter period.
    function automatic int unsigned duty_ticks(input logic [2:0] lvl,
                                               input int unsigned period);
        return (duty_pct(lvl) * period) / 100;
    endfunction

endpackage

// File: rtl/dim_counter.sv
module dim_counter #(
    parameter int unsigned PERIOD = 100,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (count == LAST)
            count <= '0;
        else
            count <= count + CW'(1);
    end
endmodule

// File: rtl/duty_gen.sv
module duty_gen
    import blank_dim_pkg::*;
#(
    parameter int unsigned PERIOD = 100,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input  logic [CW-1:0] count,
    input  logic [2:0]    level,
    output logic          dim_ok,
    output logic          half_ok
);
    localparam logic [CW:0] HALF = (CW+1)'(PERIOD / 2);

    logic [CW:0] thr;

    always_comb begin
        thr     = (CW+1)'(duty_ticks(level, PERIOD));
        dim_ok  = {1'b0, count} < thr;
        half_ok = {1'b0, count} < HALF;
    end
endmodule

// File: rtl/digit_lane.sv
module digit_lane
    import blank_dim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  blank_n,
    input  logic  cursor_en,
    input  ctrl_t ctrl,
    input  attr_t attr,
    input  logic  dim_ok,
    input  logic  half_ok,
    output logic  drive_q,
    output logic  cursor_q
);
    logic pin_blank, reg_blank, shield, lit, cur, drive_d;

    always_comb begin
        pin_blank = !blank_n;
        reg_blank = !ctrl.compat && ctrl.mblank;
        shield    = !ctrl.compat && attr.keep_lit;
        lit       = !((pin_blank || reg_blank) && !shield);
        cur       = cursor_en && attr.cursor;
        drive_d   = lit && (ctrl.compat || dim_ok) && (!cur || half_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q  <= 1'b0;
            cursor_q <= 1'b0;
        end else begin
            drive_q  <= drive_d;
            cursor_q <= cur;
        end
    end
endmodule

// File: rtl/blank_dim_gate.sv
module blank_dim_gate
    import blank_dim_pkg::*;
#(
    parameter int unsigned DIGITS     = 4,
    parameter int unsigned DIM_PERIOD = 100,
    localparam int unsigned CW        = $clog2(DIM_PERIOD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blank_n_i,
    input  logic              cursor_en_i,
    input  logic              compat_i,
    input  logic              master_blank_i,
    input  logic [2:0]        level_i,
    input  logic [DIGITS-1:0] cursor_bits_i,
    input  logic [DIGITS-1:0] keep_lit_i,
    output logic [DIGITS-1:0] drive_en_o,
    output logic [DIGITS-1:0] show_cursor_o
);
    logic [CW-1:0] dim_count;
    logic          dim_ok, half_ok;
    ctrl_t         ctrl;

    assign ctrl = '{compat: compat_i, mblank: master_blank_i, level: level_i};

    dim_counter #(.PERIOD(DIM_PERIOD)) u_count (
        .clk   (clk),
        .rst   (rst),
        .count (dim_count)
    );

    duty_gen #(.PERIOD(DIM_PERIOD)) u_duty (
        .count   (dim_count),
        .level   (level_i),
        .dim_ok  (dim_ok),
        .half_ok (half_ok)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_lane
        attr_t attr;
        assign attr = '{cursor: cursor_bits_i[d], keep_lit: keep_lit_i[d]};

        digit_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .blank_n   (blank_n_i),
            .cursor_en (cursor_en_i),
            .ctrl      (ctrl),
            .attr      (attr),
            .dim_ok    (dim_ok),
            .half_ok   (half_ok),
            .drive_q   (drive_en_o[d]),
            .cursor_q  (show_cursor_o[d])
        );
    end
endmodule

// File: rtl/blank_dim_gate_chk.sv
module blank_dim_gate_chk
    import blank_dim_pkg::*;
#(
    parameter int unsigned DIGITS = 4,
    parameter int unsigned PERIOD = 100,
    localparam int unsigned CW    = $clog2(PERIOD)
) (
    input logic              clk,
    input logic              rst,
    input logic              blank_n_i,
    input logic              cursor_en_i,
    input logic              compat_i,
    input logic              master_blank_i,
    input logic [2:0]        level_i,
    input logic [DIGITS-1:0] cursor_bits_i,
    input logic [DIGITS-1:0] keep_lit_i,
    input logic [DIGITS-1:0] drive_en_o,
    input logic [DIGITS-1:0] show_cursor_o,
    input logic [CW-1:0]     count
);
    localparam logic [CW:0] HALF = (CW+1)'(PERIOD / 2);

    logic [CW:0]       thr;
    logic [DIGITS-1:0] cur_req;

    always_comb begin
        thr     = (CW+1)'(duty_ticks(level_i, PERIOD));
        cur_req = cursor_en_i ? cursor_bits_i : '0;
    end

    // R2: in compatibility mode the pin alone blanks
    p_compat_pin_r2: assert property (@(posedge clk) disable iff (rst)
        (compat_i && !blank_n_i) |=> drive_en_o == '0);

    // R2: in compatibility mode full duty when pin high, no cursor
    p_compat_full_r2: assert property (@(posedge clk) disable iff (rst)
        (compat_i && blank_n_i && !cursor_en_i) |=> drive_en_o == '1);

    // R3: shielded positions stay lit under pin or master blank at full level
    p_keep_lit_r3: assert property (@(posedge clk) disable iff (rst)
        (!compat_i && (!blank_n_i || master_blank_i) && !cursor_en_i && level_i == 3'd0)
        |=> drive_en_o == $past(keep_lit_i));

    // R4: above the level threshold nothing is driven
    p_dim_dark_r4: assert property (@(posedge clk) disable iff (rst)
        (!compat_i && {1'b0, count} >= thr) |=> drive_en_o == '0);

    // R5: count stays within its period
    p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
        {1'b0, count} < (CW+1)'(PERIOD));

    // R6: cursor select follows enable and per-position bits
    p_cursor_sel_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> show_cursor_o == $past(cur_req));

    // R7: cursor positions dark in second half of period
    p_cursor_half_r7: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, count} >= HALF) |=> (drive_en_o & $past(cur_req)) == '0);
endmodule

bind blank_dim_gate blank_dim_gate_chk #(.DIGITS(DIGITS), .PERIOD(DIM_PERIOD)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .blank_n_i      (blank_n_i),
    .cursor_en_i    (cursor_en_i),
    .compat_i       (compat_i),
    .master_blank_i (master_blank_i),
    .level_i        (level_i),
    .cursor_bits_i  (cursor_bits_i),
    .keep_lit_i     (keep_lit_i),
    .drive_en_o     (drive_en_o),
    .show_cursor_o  (show_cursor_o),
    .count          (dim_count)
);

// File: tb/blank_dim_gate_bench.sv
module blank_dim_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDIG       = 4;
    localparam int TICKS      = 100;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            blank_n = 1'b1, cen = 1'b0, compat = 1'b0, mblank = 1'b0;
    logic [2:0]      level = 3'd0;
    logic [NDIG-1:0] cbits = '0, keep = '0;
    logic [NDIG-1:0] drive, scur;

    int checks = 0, fails = 0;
    int mcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blank_dim_gate u_blank_dim_gate (
        .clk(clk), .rst(rst), .blank_n_i(blank_n), .cursor_en_i(cen),
        .compat_i(compat), .master_blank_i(mblank), .level_i(level),
        .cursor_bits_i(cbits), .keep_lit_i(keep),
        .drive_en_o(drive), .show_cursor_o(scur));

    function automatic int pct(input logic [2:0] l);
        int t [8] = '{100, 60, 40, 27, 17, 10, 7, 3};
        return t[l];
    endfunction

    function automatic logic [NDIG-1:0] want_drive(input int c);
        logic [NDIG-1:0] r;
        for (int d = 0; d < NDIG; d++) begin
            logic blk, dim, cu;
            blk  = compat ? !blank_n : ((!blank_n || mblank) && !keep[d]);
            dim  = compat ? 1'b1 : (c < pct(level));
            cu   = cen && cbits[d];
            r[d] = !blk && dim && (!cu || c < TICKS/2);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NDIG-1:0] act, input logic [NDIG-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Inputs are set before this call, at a falling edge; one edge is taken and
    // outputs are compared at the following falling edge.
    task automatic step();
        logic [NDIG-1:0] ed, ec;
        string tag;
        ed = want_drive(mcnt);
        ec = cen ? cbits : '0;
        if (compat)                        tag = "R2";
        else if (!blank_n || mblank)       tag = "R3";
        else if (cen && cbits != '0)       tag = "R7";
        else                               tag = "R4";
        @(posedge clk);
        mcnt = (mcnt + 1) % TICKS;
        @(negedge clk);
        check(tag, drive, ed);
        check("R6", scur, ec);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", drive, '0);
        check("R1", scur, '0);
        rst = 1'b0;
        mcnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        blank_n = 1'b1; cen = 1'b1; cbits = 4'hF; compat = 1'b1;
        do_reset();

        // R5: level 7 lights counts 0..2, then dark, then again at 100
        cen = 1'b0; compat = 1'b0; level = 3'd7;
        for (int i = 0; i < 103; i++) begin
            logic [NDIG-1:0] e;
            e = (i < 3 || i >= 100) ? 4'hF : 4'h0;
            @(posedge clk); mcnt = (mcnt + 1) % TICKS;
            @(negedge clk);
            check("R5", drive, e);
        end

        // R4: count driven ticks per 100-cycle window for each level
        for (int l = 0; l < 8; l++) begin
            int on;
            level = 3'(l);
            step();
            on = 0;
            for (int i = 0; i < TICKS; i++) begin
                step();
                if (drive[0]) on++;
            end
            check("R4", 4'(on > 15 ? 0 : 0) | 4'(on == pct(3'(l))), 4'h1);
        end

        // R3: keep-lit shields against master blank and pin
        level = 3'd0; mblank = 1'b1; keep = 4'b1010; step();
        check("R3", drive, 4'b1010);
        mblank = 1'b0; blank_n = 1'b0; keep = 4'b0001; step();
        check("R3", drive, 4'b0001);

        // R2: compat mode ignores master blank, keep and level
        compat = 1'b1; blank_n = 1'b1; mblank = 1'b1; level = 3'd7; keep = '0; step();
        check("R2", drive, 4'hF);
        blank_n = 1'b0; keep = 4'hF; step();
        check("R2", drive, 4'h0);

        // R9: cursor select unaffected by blanking sources
        cen = 1'b1; cbits = 4'b0101; compat = 1'b0; mblank = 1'b1; step();
        check("R9", scur, 4'b0101);

        // R8: one-edge latency
        cen = 1'b0; mblank = 1'b0; blank_n = 1'b1; level = 3'd0; keep = '0; step();
        blank_n = 1'b0;
        #1 check("R8", drive, 4'hF);
        step();
        check("R8", drive, 4'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            blank_n = ($urandom % 8) != 0;
            cen     = $urandom % 2;
            compat  = $urandom % 2;
            mblank  = ($urandom % 6) == 0;
            level   = 3'($urandom % 8);
            cbits   = 4'($urandom);
            keep    = 4'($urandom);
            step();
        end

        // R1: reset mid-run clears outputs and restarts count
        do_reset();
        blank_n = 1'b1; compat = 1'b0; mblank = 1'b0; cen = 1'b0; level = 3'd1;
        for (int i = 0; i < 120; i++) step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule